// File: doc/BRIEF.md
# CAN channel mode controller

This block holds the operating mode of one CAN channel. It has four top-level modes: stop, reset, halt and communication. Inside communication it follows a sub-state that is one of integrating, idle, receiving, transmitting or bus-off. Software steers the block with three inputs: a sleep bit, a two-bit mode request and a two-bit bus-off recovery policy. The bit engine supplies the rest: the sampled bus level (1 is recessive), a one-cycle strobe per bit time, frame events, and the transmit error count.

The channel joins the bus only after it sees a run of 11 recessive bits 128 times. A dominant bit restarts the current run but keeps the runs already counted. A bus held dominant for 11 or more bit times blocks every move into halt mode. A reset request is still accepted in that case.

Top module: `can_chan_mode`

## Requirements
- R1: After `rst_n` is released the channel is in stop mode (`mode` = 00) and `busoff`, `txing`, `rxing` and `comm_rdy` are all 0. The other mode codes are 01 reset, 10 halt and 11 communication.
- R2: From stop, a 0 on `sleep_req` moves the channel to reset. From reset, a 1 on `sleep_req` moves it back to stop. `sleep_req` has no effect in halt or communication.
- R3: The `mode_req` codes are 01 reset, 00 communication and 10 halt. From reset the channel goes to communication on 00, or to halt on 10. From halt it goes to reset on 01, or to communication on 00. From communication it goes to reset on 01, or to halt on 10. Code 11, and any code received in stop mode, is ignored.
- R4: On entering communication all four flags are 0. The channel moves to idle (`comm_rdy` = 1) on the `bit_tick` that completes the 128th run of 11 recessive bits. A dominant bit clears only the run in progress.
- R5: The flags {`busoff`,`txing`,`rxing`,`comm_rdy`} read 0001 in idle, 0011 in receiving, 0101 in transmitting and 1101 in bus-off.
- R6: From idle, `tx_start` enters transmitting, and it takes priority over `sof_det`. `sof_det` alone enters receiving. `arb_lost` moves transmitting to receiving. `frame_done` returns receiving or transmitting to idle.
- R7: A `tec` value above 255 in idle, receiving or transmitting enters bus-off when `recov_sel` is 00, 10 or 11.
- R8: With `recov_sel` = 00, bus-off returns to idle after the 11-bit recessive run has been seen 128 times.
- R9: With `recov_sel` = 01, a `tec` value above 255 moves the channel straight to halt.
- R10: With `recov_sel` = 10, bus-off moves to halt after the 11-bit recessive run has been seen 128 times, and not before.
- R11: With `recov_sel` = 11, bus-off is held until `mode_req` = 10, which moves the channel to halt.
- R12: Once `bit_tick` has sampled a dominant bus 11 times in a row, no move into halt happens until a recessive bit is sampled. A reset request is still honoured during that time.
- R13: In stop, reset and halt modes all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Sleep request from software |
| mode_req | input | 2 | Mode request code |
| recov_sel | input | 2 | Bus-off recovery policy |
| bus_rx | input | 1 | Sampled bus level, 1 = recessive |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| sof_det | input | 1 | Start of frame detected |
| tx_start | input | 1 | Own transmission starts |
| arb_lost | input | 1 | Arbitration lost |
| frame_done | input | 1 | Frame finished |
| tec | input | TEC_W | Transmit error count |
| mode | output | 2 | Current top-level mode |
| busoff | output | 1 | Bus-off flag |
| txing | output | 1 | Transmitting flag |
| rxing | output | 1 | Receiving flag |
| comm_rdy | output | 1 | Communication-ready flag |

## Verification
The hardest cases to reach are the policy-dependent exits from bus-off and the halt block under a stuck-dominant bus. Each needs a long, exact count of bit strobes. The stimulus first drives a partial run that a dominant bit cuts short. It then drives exactly 1407 recessive strobes, checks that the channel has not yet moved, and drives one more strobe to check that it moves on that edge. For the stuck case the bench drives 11 dominant strobes and holds a halt request for several cycles. It then shows that a reset request still goes through, and that halt is accepted once a recessive bit has been sampled.

// File: rtl/can_chan_mode.sv
module can_chan_mode #(
  parameter int TEC_W     = 9,
  parameter int TEC_LIMIT = 255,
  parameter int RUN_LEN   = 11,
  parameter int RUN_CNT   = 128,
  parameter int STUCK_LEN = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic [1:0]       mode_req,
  input  logic [1:0]       recov_sel,
  input  logic             bus_rx,
  input  logic             bit_tick,
  input  logic             sof_det,
  input  logic             tx_start,
  input  logic             arb_lost,
  input  logic             frame_done,
  input  logic [TEC_W-1:0] tec,
  output logic [1:0]       mode,
  output logic             busoff,
  output logic             txing,
  output logic             rxing,
  output logic             comm_rdy
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam int OCC_W = $clog2(RUN_CNT + 1);
  localparam int DOM_W = $clog2(STUCK_LEN + 1);

  localparam logic [1:0] M_STOP  = 2'b00;
  localparam logic [1:0] M_RESET = 2'b01;
  localparam logic [1:0] M_HALT  = 2'b10;
  localparam logic [1:0] M_COMM  = 2'b11;

  localparam logic [1:0] Q_COMM  = 2'b00;
  localparam logic [1:0] Q_RESET = 2'b01;
  localparam logic [1:0] Q_HALT  = 2'b10;

  typedef enum logic [2:0] {S_SYNC, S_IDLE, S_RX, S_TX, S_BOFF} sub_t;

  logic [1:0]       mode_q, mode_n;
  sub_t             sub_q, sub_n;
  logic [RUN_W-1:0] run_q;
  logic [OCC_W-1:0] occ_q;
  logic [DOM_W-1:0] dom_q;
  logic             stuck, tec_ovf, counting, run_hit, integ_done;

  assign stuck      = dom_q >= DOM_W'(STUCK_LEN);
  assign tec_ovf    = tec > TEC_W'(TEC_LIMIT);
  assign counting   = (mode_q == M_COMM) && (sub_q == S_SYNC || sub_q == S_BOFF);
  assign run_hit    = counting && bit_tick && bus_rx && (run_q == RUN_W'(RUN_LEN - 1));
  assign integ_done = run_hit && (occ_q == OCC_W'(RUN_CNT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_q <= '0;
    end else if (bit_tick) begin
      if (bus_rx)      dom_q <= '0;
      else if (!stuck) dom_q <= dom_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      occ_q <= '0;
    end else if (!counting || integ_done) begin
      run_q <= '0;
      occ_q <= '0;
    end else if (bit_tick) begin
      if (!bus_rx) begin
        run_q <= '0;
      end else if (run_hit) begin
        run_q <= '0;
        occ_q <= occ_q + 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  always_comb begin
    mode_n = mode_q;
    sub_n  = sub_q;
    unique case (mode_q)
      M_STOP:  if (!sleep_req) mode_n = M_RESET;
      M_RESET: begin
        if (sleep_req)                         mode_n = M_STOP;
        else if (mode_req == Q_COMM)           mode_n = M_COMM;
        else if (mode_req == Q_HALT && !stuck) mode_n = M_HALT;
      end
      M_HALT: begin
        if (mode_req == Q_RESET)     mode_n = M_RESET;
        else if (mode_req == Q_COMM) mode_n = M_COMM;
      end
      default: begin
        if (mode_req == Q_RESET) begin
          mode_n = M_RESET;
        end else if (mode_req == Q_HALT && !stuck) begin
          mode_n = M_HALT;
        end else begin
          unique case (sub_q)
            S_SYNC: if (integ_done) sub_n = S_IDLE;
            S_BOFF: begin
              if (recov_sel == 2'b01 && !stuck) mode_n = M_HALT;
              else if (integ_done && recov_sel == 2'b00) sub_n = S_IDLE;
              else if (integ_done && recov_sel == 2'b10) mode_n = M_HALT;
            end
            default: begin
              if (tec_ovf) begin
                if (recov_sel == 2'b01 && !stuck) mode_n = M_HALT;
                else sub_n = S_BOFF;
              end else if (sub_q == S_IDLE) begin
                if (tx_start)     sub_n = S_TX;
                else if (sof_det) sub_n = S_RX;
              end else if (frame_done) begin
                sub_n = S_IDLE;
              end else if (sub_q == S_TX && arb_lost) begin
                sub_n = S_RX;
              end
            end
          endcase
        end
      end
    endcase
    if (mode_n != M_COMM) sub_n = S_SYNC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_STOP;
      sub_q  <= S_SYNC;
    end else begin
      mode_q <= mode_n;
      sub_q  <= sub_n;
    end
  end

  assign mode     = mode_q;
  assign busoff   = (mode_q == M_COMM) && (sub_q == S_BOFF);
  assign txing    = (mode_q == M_COMM) && (sub_q == S_TX || sub_q == S_BOFF);
  assign rxing    = (mode_q == M_COMM) && (sub_q == S_RX);
  assign comm_rdy = (mode_q == M_COMM) && (sub_q != S_SYNC);

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STOP && sleep_req) |=> (mode == M_STOP));

  // R3
  stop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STOP) |=> (mode == M_STOP || mode == M_RESET));

  // R13
  flags_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_COMM) |-> !(busoff || txing || rxing || comm_rdy));

  // R12
  stuck_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stuck && !(bit_tick && bus_rx) && mode != M_HALT) |=> (mode != M_HALT));

  // R9
  direct_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_COMM && comm_rdy && !busoff && tec_ovf && recov_sel == 2'b01 &&
     mode_req == Q_COMM && !stuck) |=> (mode == M_HALT));

  // R4
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_COMM && $rose(comm_rdy) && $past(mode) == M_COMM) |-> $past(bit_tick && bus_rx));
endmodule

// File: tb/can_chan_mode_test.sv
`timescale 1ns/100ps
module can_chan_mode_test;
  logic       clk = 0, rst_n = 0;
  logic       sleep_req = 1, bus_rx = 1, bit_tick = 0;
  logic [1:0] mode_req = 2'b01, recov_sel = 2'b11;
  logic       sof_det = 0, tx_start = 0, arb_lost = 0, frame_done = 0;
  logic [8:0] tec = 9'd0;
  logic [1:0] mode;
  logic       busoff, txing, rxing, comm_rdy;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  can_chan_mode uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .mode_req(mode_req),
    .recov_sel(recov_sel), .bus_rx(bus_rx), .bit_tick(bit_tick),
    .sof_det(sof_det), .tx_start(tx_start), .arb_lost(arb_lost),
    .frame_done(frame_done), .tec(tec), .mode(mode), .busoff(busoff),
    .txing(txing), .rxing(rxing), .comm_rdy(comm_rdy)
  );

  // row: sleep, mreq[2], recov[2], sof, tx, arb, fd, tec_ovf, exp_mode[2], exp_flags[4]
  localparam logic [15:0] VEC [14] = '{
    {1'b0, 2'b00, 2'b11, 4'b1000, 1'b0, 2'b11, 4'b0011},  // R6 sof -> rx
    {1'b0, 2'b00, 2'b11, 4'b0001, 1'b0, 2'b11, 4'b0001},  // R6 rx -> idle
    {1'b0, 2'b00, 2'b11, 4'b0100, 1'b0, 2'b11, 4'b0101},  // R5 tx
    {1'b0, 2'b00, 2'b11, 4'b0010, 1'b0, 2'b11, 4'b0011},  // R6 arb lost
    {1'b0, 2'b00, 2'b11, 4'b0001, 1'b0, 2'b11, 4'b0001},  // R5 idle
    {1'b0, 2'b00, 2'b11, 4'b1100, 1'b0, 2'b11, 4'b0101},  // R6 tx priority
    {1'b0, 2'b00, 2'b11, 4'b0001, 1'b0, 2'b11, 4'b0001},  // R6 tx -> idle
    {1'b0, 2'b11, 2'b11, 4'b0000, 1'b0, 2'b11, 4'b0001},  // R3 code 11 ignored
    {1'b1, 2'b00, 2'b11, 4'b0000, 1'b0, 2'b11, 4'b0001},  // R2 sleep ignored
    {1'b0, 2'b00, 2'b11, 4'b0100, 1'b0, 2'b11, 4'b0101},
    {1'b0, 2'b00, 2'b11, 4'b0000, 1'b1, 2'b11, 4'b1101},  // R7 bus-off
    {1'b0, 2'b00, 2'b11, 4'b0000, 1'b0, 2'b11, 4'b1101},  // R11 held
    {1'b0, 2'b10, 2'b11, 4'b0000, 1'b0, 2'b10, 4'b0000},  // R11 halt on code
    {1'b0, 2'b00, 2'b11, 4'b0000, 1'b0, 2'b11, 4'b0000}   // R3 R4 back to comm
  };

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [1:0] em, input logic [3:0] ef);
    logic [3:0] af;
    af = {busoff, txing, rxing, comm_rdy};
    checks++;
    if (mode !== em || af !== ef) begin
      errors++;
      $display("FAIL %s: mode=%b flags=%b expected mode=%b flags=%b", tag, mode, af, em, ef);
    end
  endtask

  task automatic ticks(input int n, input logic lvl);
    for (int i = 0; i < n; i++) begin
      bus_rx = lvl; bit_tick = 1; cyc(); bit_tick = 0;
    end
    bus_rx = 1;
  endtask

  task automatic pulse_tec();
    tec = 9'd300; cyc(); tec = 9'd10;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #12; cyc();
    chk("R1 reset state", 2'b00, 4'b0000);
    rst_n = 1; cyc(); cyc();
    chk("R2 sleep holds stop", 2'b00, 4'b0000);
    sleep_req = 0; mode_req = 2'b00;
    cyc();
    chk("R3 stop ignores code 00; R2 to reset", 2'b01, 4'b0000);
    mode_req = 2'b11; cyc();
    chk("R3 code 11 ignored in reset", 2'b01, 4'b0000);
    sleep_req = 1; cyc();
    chk("R2 back to stop", 2'b00, 4'b0000);
    sleep_req = 0; mode_req = 2'b01; cyc();
    mode_req = 2'b00; cyc();
    chk("R4 enter comm, integrating", 2'b11, 4'b0000);
    ticks(10, 1'b1); ticks(1, 1'b0); ticks(1407, 1'b1);
    chk("R4 dominant restarts run", 2'b11, 4'b0000);
    ticks(1, 1'b1);
    chk("R4 ready after 128 runs", 2'b11, 4'b0001);

    for (int r = 0; r < 14; r++) begin
      logic [15:0] v;
      v = VEC[r];
      sleep_req = v[15]; mode_req = v[14:13]; recov_sel = v[12:11];
      sof_det = v[10]; tx_start = v[9]; arb_lost = v[8]; frame_done = v[7];
      tec = v[6] ? 9'd300 : 9'd10;
      cyc();
      sof_det = 0; tx_start = 0; arb_lost = 0; frame_done = 0; tec = 9'd10; sleep_req = 0;
      chk($sformatf("table row %0d (R2 R3 R5 R6 R7 R11)", r), v[5:4], v[3:0]);
    end

    // R8
    recov_sel = 2'b00;
    ticks(1408, 1'b1);
    tx_start = 1; cyc(); tx_start = 0;
    pulse_tec();
    chk("R8 bus-off entered", 2'b11, 4'b1101);
    ticks(1407, 1'b1);
    chk("R8 still bus-off", 2'b11, 4'b1101);
    ticks(1, 1'b1);
    chk("R8 recovered to idle", 2'b11, 4'b0001);

    // R9
    recov_sel = 2'b01;
    pulse_tec();
    chk("R9 direct halt", 2'b10, 4'b0000);
    chk("R13 halt flags clear", 2'b10, 4'b0000);

    // R10
    recov_sel = 2'b10;
    mode_req = 2'b00; cyc();
    ticks(1408, 1'b1);
    pulse_tec();
    chk("R10 bus-off first", 2'b11, 4'b1101);
    ticks(1407, 1'b1);
    chk("R10 not yet halted", 2'b11, 4'b1101);
    ticks(1, 1'b1);
    chk("R10 halt after integration", 2'b10, 4'b0000);

    // R12
    mode_req = 2'b00; cyc();
    ticks(11, 1'b0);
    mode_req = 2'b10; cyc(); cyc(); cyc();
    chk("R12 halt blocked while stuck", 2'b11, 4'b0000);
    mode_req = 2'b01; cyc();
    chk("R12 reset accepted while stuck", 2'b01, 4'b0000);
    mode_req = 2'b10; cyc(); cyc();
    chk("R12 halt blocked from reset", 2'b01, 4'b0000);
    ticks(1, 1'b1); cyc();
    chk("R12 halt after recessive bit", 2'b10, 4'b0000);
    mode_req = 2'b01; cyc();
    chk("R13 reset flags clear", 2'b01, 4'b0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule